// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Edge Interrupts

This block is a register-mapped general purpose I/O controller. Its pins are split into banks of equal width (two banks of sixteen by default). Every bank has its own set of six registers: pin direction, sampled input level, output level, trigger polarity, trigger enable and a sticky event flag. Software reaches them through a plain single-cycle register bus. A write takes effect on the next clock edge. A read is combinational from the address.

Every pin level passes through a multi-stage synchronizer. The synchronized value is then compared with its own registered previous value. A pin that is an input, has its trigger enabled, and moves in the polarity it selected sets its flag bit. A flag bit stays set until software writes a one to that bit position. All flag bits of all banks are reduced to a single active-low interrupt request. That request stays low until every flag in every bank has been cleared.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register in every bank reads 0, `pin_oe` and `pin_out` are all zero, and `irq_n` is high.
- R2: Bit i of `pin_oe` equals direction bit i (1 = output, 0 = input). Bit i of `pin_out` equals output register bit i when that pin is an output, and 0 when it is an input.
- R3: The input register returns each input pin's level as seen after the synchronizer (two clocks after a change, with the default depth). Bits of output pins read 0. Writes to the input register change nothing.
- R4: A pin with polarity bit 0 (rising) sets its flag on a 0-to-1 change. The flag becomes visible after the third rising clock edge that follows the pin change.
- R5: A pin with polarity bit 1 (falling) sets its flag on a 1-to-0 change. A 0-to-1 change alone never sets its flag.
- R6: No flag is set when the trigger enable bit is 0, when the pin is an output, or when only the polarity or enable bits change while the pin holds a steady level.
- R7: Writing the flag register clears the bits written as 1 and leaves the bits written as 0 unchanged. A flag is never cleared without such a write.
- R8: When a qualifying edge and a clearing write to the same flag bit meet in one cycle, the flag ends up set.
- R9: `irq_n` is low while any flag bit in any bank is set. It returns high only once all flags are clear.
- R10: Bank b occupies word addresses 6*b to 6*b+5, in this order: direction, input, output, polarity, enable, flag. Addresses beyond the last bank read 0, and writes to them change nothing.
- R11: The direction, output, polarity and enable registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Read data for `bus_addr` (combinational) |
| pin_in | input | NUM_BANKS*BANK_W | Pin levels from the pads (asynchronous) |
| pin_out | output | NUM_BANKS*BANK_W | Levels driven onto output pins |
| pin_oe | output | NUM_BANKS*BANK_W | Output enable per pin (1 = drive) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: two banks of sixteen pins, a four-bit address and a two-stage synchronizer. With a four-bit address there are sixteen words for twelve registers, so the four unmapped words at the top can be read and written. With two banks, an interrupt held by one bank while the other is cleared can be checked, and so can every bank-boundary decode. With a depth of two, the edge-to-flag latency is a fixed three clocks. That makes it possible to place a clearing write exactly in the cycle where a new edge lands.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int REGS_PER_BANK = 6;

   typedef enum logic [2:0] {
      OFS_DIR  = 3'd0,
      OFS_IN   = 3'd1,
      OFS_OUT  = 3'd2,
      OFS_POL  = 3'd3,
      OFS_EN   = 3'd4,
      OFS_FLAG = 3'd5
   } reg_ofs_e;

   // word index of a register inside the flat map
   function automatic int reg_index(input int bank, input reg_ofs_e ofs);
      return bank * REGS_PER_BANK + int'(ofs);
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_err_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_err_w
      $error("gpio_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_dir_i,
   input  logic         we_out_i,
   input  logic         we_pol_i,
   input  logic         we_en_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] dir_o,
   output logic [W-1:0] out_o,
   output logic [W-1:0] pol_o,
   output logic [W-1:0] en_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_o <= '0;
         out_o <= '0;
         pol_o <= '0;
         en_o  <= '0;
      end else begin
         if (we_dir_i) dir_o <= wdata_i;
         if (we_out_i) out_o <= wdata_i;
         if (we_pol_i) pol_o <= wdata_i;
         if (we_en_i)  en_o  <= wdata_i;
      end
   end

endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] dir_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] en_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flag_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] rise;
   logic [W-1:0] fall;
   logic [W-1:0] hit;

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign hit[i] = en_i[i] & ~dir_i[i] & (pol_i[i] ? fall[i] : rise[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag_o <= '0;
      end else begin
         prev_q <= lvl_i;
         flag_o <= (flag_o & ~clr_i) | hit;
      end
   end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gpio_edge_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_W      = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_we,
   input  logic [BANK_W-1:0]           bus_wdata,
   output logic [BANK_W-1:0]           bus_rdata,
   input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
   output logic [NUM_BANKS*BANK_W-1:0] pin_out,
   output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
   output logic                        irq_n
);

   localparam int PINS     = NUM_BANKS * BANK_W;
   localparam int NUM_REGS = NUM_BANKS * REGS_PER_BANK;

   if (NUM_BANKS < 1) begin : g_err_banks
      $error("gpio_edge_irq: NUM_BANKS must be at least 1");
   end
   if (BANK_W < 1) begin : g_err_width
      $error("gpio_edge_irq: BANK_W must be positive");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_err_addr
      $error("gpio_edge_irq: ADDR_W too small for the register map");
   end

   logic [PINS-1:0] sync_all;
   logic [PINS-1:0] dir_all;
   logic [PINS-1:0] out_all;
   logic [PINS-1:0] pol_all;
   logic [PINS-1:0] en_all;
   logic [PINS-1:0] flag_all;
   logic [PINS-1:0] in_all;

   gpio_sync #(
      .W      (PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (sync_all)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic we_dir, we_out, we_pol, we_en, we_flag;
      logic [BANK_W-1:0] clr;

      assign we_dir  = bus_we && (bus_addr == ADDR_W'(reg_index(b, OFS_DIR)));
      assign we_out  = bus_we && (bus_addr == ADDR_W'(reg_index(b, OFS_OUT)));
      assign we_pol  = bus_we && (bus_addr == ADDR_W'(reg_index(b, OFS_POL)));
      assign we_en   = bus_we && (bus_addr == ADDR_W'(reg_index(b, OFS_EN)));
      assign we_flag = bus_we && (bus_addr == ADDR_W'(reg_index(b, OFS_FLAG)));
      assign clr     = we_flag ? bus_wdata : '0;

      gpio_bank_cfg #(
         .W (BANK_W)
      ) u_cfg (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_dir_i (we_dir),
         .we_out_i (we_out),
         .we_pol_i (we_pol),
         .we_en_i  (we_en),
         .wdata_i  (bus_wdata),
         .dir_o    (dir_all[b*BANK_W +: BANK_W]),
         .out_o    (out_all[b*BANK_W +: BANK_W]),
         .pol_o    (pol_all[b*BANK_W +: BANK_W]),
         .en_o     (en_all[b*BANK_W +: BANK_W])
      );

      gpio_edge_flag #(
         .W (BANK_W)
      ) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl_i  (sync_all[b*BANK_W +: BANK_W]),
         .dir_i  (dir_all[b*BANK_W +: BANK_W]),
         .pol_i  (pol_all[b*BANK_W +: BANK_W]),
         .en_i   (en_all[b*BANK_W +: BANK_W]),
         .clr_i  (clr),
         .flag_o (flag_all[b*BANK_W +: BANK_W])
      );
   end

   assign in_all = sync_all & ~dir_all;

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bus_addr == ADDR_W'(reg_index(b, OFS_DIR)))  bus_rdata = dir_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(reg_index(b, OFS_IN)))   bus_rdata = in_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(reg_index(b, OFS_OUT)))  bus_rdata = out_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(reg_index(b, OFS_POL)))  bus_rdata = pol_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(reg_index(b, OFS_EN)))   bus_rdata = en_all[b*BANK_W +: BANK_W];
         if (bus_addr == ADDR_W'(reg_index(b, OFS_FLAG))) bus_rdata = flag_all[b*BANK_W +: BANK_W];
      end
   end

   assign pin_oe  = dir_all;
   assign pin_out = out_all & dir_all;
   assign irq_n   = ~|flag_all;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
   parameter int PINS = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_we,
   input logic            irq_n,
   input logic [PINS-1:0] pin_out,
   input logic [PINS-1:0] pin_oe,
   input logic [PINS-1:0] flag_all,
   input logic [PINS-1:0] en_all,
   input logic [PINS-1:0] dir_all
);

   a_r2_drive_only_outputs: assert property (
      @(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   a_r6_flag_needs_enabled_input: assert property (
      @(posedge clk) disable iff (!rst_n)
      (flag_all & ~$past(flag_all) & ~$past(en_all & ~dir_all)) == '0);

   a_r7_flag_sticky_without_write: assert property (
      @(posedge clk) disable iff (!rst_n)
      !bus_we |=> ((flag_all & $past(flag_all)) == $past(flag_all)));

   a_r9_release_needs_write: assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(bus_we));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
   .PINS (NUM_BANKS * BANK_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .irq_n    (irq_n),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .flag_all (flag_all),
   .en_all   (en_all),
   .dir_all  (dir_all)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;

   localparam int CLK_PERIOD = 10;
   localparam int PINS = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [PINS-1:0] pin_in = '0;
   logic [PINS-1:0] pin_out;
   logic [PINS-1:0] pin_oe;
   logic        irq_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_irq i_gpio_edge_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq_n     (irq_n)
   );

   // reference model built from the requirements
   logic [PINS-1:0] m_s1, m_s2, m_prev, m_dir, m_out, m_pol, m_en, m_flag, m_hit, m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0;
         m_dir = '0; m_out = '0; m_pol = '0; m_en = '0; m_flag = '0;
      end else begin
         m_hit = ((m_s2 & ~m_prev & ~m_pol) | (~m_s2 & m_prev & m_pol)) & m_en & ~m_dir;
         m_clr = '0;
         if (bus_we) begin
            for (int b = 0; b < 2; b++) begin
               if (bus_addr == 4'(b*6+0)) m_dir[b*16 +: 16] = bus_wdata;
               if (bus_addr == 4'(b*6+2)) m_out[b*16 +: 16] = bus_wdata;
               if (bus_addr == 4'(b*6+3)) m_pol[b*16 +: 16] = bus_wdata;
               if (bus_addr == 4'(b*6+4)) m_en[b*16 +: 16]  = bus_wdata;
               if (bus_addr == 4'(b*6+5)) m_clr[b*16 +: 16] = bus_wdata;
            end
         end
         m_flag = (m_flag & ~m_clr) | m_hit;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pin_in;
      end
   end

   function automatic logic [15:0] exp_rd(input logic [3:0] a);
      int b, o;
      if (a >= 4'd12) return 16'h0;
      b = int'(a) / 6;
      o = int'(a) % 6;
      case (o)
         0: return m_dir[b*16 +: 16];
         1: return m_s2[b*16 +: 16] & ~m_dir[b*16 +: 16];
         2: return m_out[b*16 +: 16];
         3: return m_pol[b*16 +: 16];
         4: return m_en[b*16 +: 16];
         default: return m_flag[b*16 +: 16];
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R10 unmapped words
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v);
         chk((a < 12) ? "R1 reset reg" : "R10 unmapped read", {16'h0, v}, 32'h0);
      end
      chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
      chk("R1 pin_oe", pin_oe, 32'h0);

      // R2/R11 direction and output
      wr(4'd0, 16'h00F0);
      wr(4'd2, 16'hFFFF);
      wr(4'd6, 16'h0001);
      wr(4'd8, 16'h0003);
      chk("R2 pin_oe", pin_oe, 32'h0001_00F0);
      chk("R2 pin_out", pin_out, 32'h0001_00F0);
      rd(4'd8, v); chk("R11 readback out bank1", {16'h0, v}, 32'h0003);
      wr(4'd13, 16'hBEEF);
      rd(4'd13, v); chk("R10 unmapped write", {16'h0, v}, 32'h0);
      chk("R10 unmapped write no effect", pin_oe, 32'h0001_00F0);

      // R3 input sampling through the synchronizer
      pin_in = 32'h0000_0FFF;
      @(negedge clk);
      rd(4'd1, v); chk("R3 not yet synced", {16'h0, v}, 32'h0);
      @(negedge clk);
      rd(4'd1, v); chk("R3 input masked", {16'h0, v}, 32'h0F0F);
      wr(4'd1, 16'h0000);
      rd(4'd1, v); chk("R3 write ignored", {16'h0, v}, 32'h0F0F);
      rd(4'd5, v); chk("R6 no flag while disabled", {16'h0, v}, 32'h0);
      pin_in = '0;
      repeat (4) @(negedge clk);

      // R4 rising edge and latency
      wr(4'd4, 16'h0013);
      pin_in[0] = 1'b1;
      repeat (2) @(negedge clk);
      rd(4'd5, v); chk("R4 flag not before third edge", {16'h0, v}, 32'h0);
      @(negedge clk);
      rd(4'd5, v); chk("R4 rising flag", {16'h0, v}, 32'h0001);
      chk("R9 irq low", {31'h0, irq_n}, 32'h0);

      // R5 falling select
      wr(4'd3, 16'h0002);
      pin_in[1] = 1'b1;
      repeat (4) @(negedge clk);
      rd(4'd5, v); chk("R5 rise ignored on falling pin", {16'h0, v}, 32'h0001);
      pin_in[1] = 1'b0;
      repeat (3) @(negedge clk);
      rd(4'd5, v); chk("R5 falling flag", {16'h0, v}, 32'h0003);

      // R7 write-one-to-clear
      wr(4'd5, 16'h0000);
      rd(4'd5, v); chk("R7 zero write keeps", {16'h0, v}, 32'h0003);
      wr(4'd5, 16'h0001);
      rd(4'd5, v); chk("R7 clear bit0", {16'h0, v}, 32'h0002);

      // R9 across banks
      wr(4'd10, 16'h8000);
      pin_in[31] = 1'b1;
      repeat (3) @(negedge clk);
      rd(4'd11, v); chk("R4 bank1 flag", {16'h0, v}, 32'h8000);
      wr(4'd5, 16'h0002);
      chk("R9 irq held by other bank", {31'h0, irq_n}, 32'h0);
      wr(4'd11, 16'h8000);
      chk("R9 irq released", {31'h0, irq_n}, 32'h1);

      // R6 idle config changes and output pins
      pin_in[2] = 1'b1;
      repeat (4) @(negedge clk);
      wr(4'd4, 16'h0017);
      wr(4'd3, 16'h0006);
      wr(4'd3, 16'h0002);
      wr(4'd4, 16'h0013);
      wr(4'd4, 16'h0017);
      pin_in[4] = 1'b1;
      repeat (4) @(negedge clk);
      rd(4'd5, v); chk("R6 no spurious flag", {16'h0, v}, 32'h0);

      // R8 edge wins over simultaneous clear
      pin_in[0] = 1'b0;
      repeat (4) @(negedge clk);
      pin_in[0] = 1'b1;
      repeat (3) @(negedge clk);
      rd(4'd5, v); chk("R8 setup flag", {16'h0, v}, 32'h0001);
      pin_in[0] = 1'b0;
      repeat (4) @(negedge clk);
      pin_in[0] = 1'b1;
      @(negedge clk);
      wr(4'd5, 16'h0001);
      rd(4'd5, v); chk("R8 edge wins", {16'h0, v}, 32'h0001);
      wr(4'd5, 16'h0001);
      rd(4'd5, v); chk("R7 clear after", {16'h0, v}, 32'h0);

      // random phase against the model
      for (int c = 0; c < 4000; c++) begin
         logic [3:0] a;
         chk("R9 irq model", {31'h0, irq_n}, {31'h0, ~|m_flag});
         chk("R2 oe model", pin_oe, m_dir);
         chk("R2 out model", pin_out, m_out & m_dir);
         a = 4'($urandom_range(0, 15));
         bus_we = ($urandom_range(0, 3) == 0);
         bus_wdata = 16'($urandom);
         if (bus_we && (a == 4'd0 || a == 4'd6)) bus_wdata = bus_wdata & 16'h0F0F;
         pin_in = pin_in ^ ($urandom & $urandom & $urandom);
         rd(a, v);
         chk("R10 R11 random read", {16'h0, v}, {16'h0, exp_rd(a)});
         @(negedge clk);
      end
      bus_we = 1'b0;
      @(negedge clk);
      summary();
   end

endmodule